// File: doc/BRIEF.md
# Sector Erase Batching Controller

This block gathers sector-erase requests from a host into a selection bitmap with one bit per sector. It does not start erasing on the first request. Each accepted request restarts an inactivity window. The erase starts only when that window runs out with no new request. A single erase then covers every sector queued so far. The host can keep adding sectors in any order while the window is open, and a status bit tells it whether the window is already closed.

The host side gives decoded one-cycle command strobes: add sector (with a sector address), suspend, resume, and "any other command". A counter stub stands in for the physical erase engine. It is started by the erase-start pulse, it freezes while the erase is suspended, and it reports completion after a programmable number of running cycles. When the erase completes, the block releases the bitmap and returns to its idle read state.

Strobes are expected one per cycle. If several arrive in the same cycle, the priority is: add sector, then other command, then suspend, then resume.

Top module: `sector_erase_batcher`

## Requirements
- R1: After a synchronous reset, `sel_map` is all zero and `busy`, `win_expired`, `erase_start` and `erase_done` are low.
- R2: In idle, an add-sector strobe with address A sets only bit A of `sel_map`, where bit index equals sector address. `busy` is high from the next cycle.
- R3: While the window is open, further add-sector strobes OR their bit into `sel_map` in any order. A repeated address leaves the map unchanged, and all NUM_SECTORS bits can be set.
- R4: Each accepted add-sector strobe restarts the window. If WINDOW_CYCLES cycles follow the last accepted strobe with no command, `erase_start` pulses for one cycle and `win_expired` goes high in that same cycle.
- R5: An other-command strobe while the window is open clears `sel_map`, drops `busy` and returns to idle. No erase starts.
- R6: A suspend strobe while the window is open closes it at once (`win_expired` high, `busy` high, no `erase_start`). A later resume strobe produces the `erase_start` pulse in the next cycle.
- R7: While the erase runs, add-sector and other-command strobes are ignored: `sel_map`, `busy` and `win_expired` keep their values.
- R8: A suspend strobe during the erase freezes the erase engine, so no `erase_done` appears however long the suspension lasts. A resume strobe lets the erase continue to completion.
- R9: Without suspension, `erase_done` pulses for one cycle ERASE_CYCLES+2 cycles after `erase_start`. In that cycle `sel_map` is zero and `busy` and `win_expired` are low.
- R10: A synchronous reset in any phase (window open, erasing) clears the bitmap, the window and the engine. No later `erase_start` or `erase_done` follows from the aborted operation.
- R11: Suspend and resume strobes in idle, and resume strobes while the erase is running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_add | input | 1 | Add-sector command strobe |
| cmd_suspend | input | 1 | Erase suspend strobe |
| cmd_resume | input | 1 | Erase resume strobe |
| cmd_other | input | 1 | Any other host command strobe |
| sec_addr | input | $clog2(NUM_SECTORS) | Sector address qualifying `cmd_add` |
| sel_map | output | NUM_SECTORS | Sectors selected for the pending or running erase |
| erase_start | output | 1 | One-cycle pulse launching the erase engine |
| busy | output | 1 | High from first accepted add until completion or abort |
| win_expired | output | 1 | Acceptance window closed; further adds are not taken |
| erase_done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets four behaviours.

- **Window length.** A window one cycle too short or too long would move the `erase_start` pulse off its expected cycle. A design that failed to restart the window on an addition would start the erase too early.
- **Abort versus suspend.** Confusing these would either keep the bitmap after a foreign command or launch an erase the host cancelled.
- **Commands during the erase.** A design that let commands through while erasing would corrupt the bitmap.
- **Engine freeze.** A design whose engine kept counting while suspended would raise `erase_done` during the suspension.

// File: rtl/sebc_pkg.sv
package sebc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_ERASE  = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;

    typedef struct packed {
        logic add;
        logic abort;
        logic halt;
        logic go_on;
    } cmd_t;

    // One command per cycle; simultaneous strobes resolved by fixed priority.
    function automatic cmd_t cmd_pick(input logic add, input logic abort,
                                      input logic halt, input logic go_on);
        cmd_t c;
        c = '0;
        if (add)        c.add   = 1'b1;
        else if (abort) c.abort = 1'b1;
        else if (halt)  c.halt  = 1'b1;
        else if (go_on) c.go_on = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/sebc_sel_decode.sv
module sebc_sel_decode #(
    parameter int NUM_SECTORS = 16,
    parameter int AW          = 4
) (
    input  logic [AW-1:0]          addr,
    output logic [NUM_SECTORS-1:0] onehot,
    output logic                   valid
);
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        assign onehot[i] = (addr == AW'(i));
    end
    assign valid = |onehot;
endmodule

// File: rtl/sebc_window.sv
module sebc_window #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic last
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (run && cnt_q != LAST_V)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_V);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_V);

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/sebc_engine.sv
module sebc_engine #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(CYCLES - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q && !hold) begin
                if (cnt_q == LAST_V) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign done = done_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !active_q);

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (hold && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher
    import sebc_pkg::*;
#(
    parameter int NUM_SECTORS   = 16,
    parameter int WINDOW_CYCLES = 5000,
    parameter int ERASE_CYCLES  = 2000,
    localparam int AW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_add,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic                   cmd_other,
    input  logic [AW-1:0]          sec_addr,
    output logic [NUM_SECTORS-1:0] sel_map,
    output logic                   erase_start,
    output logic                   busy,
    output logic                   win_expired,
    output logic                   erase_done
);
    phase_e                 phase_q;
    logic [NUM_SECTORS-1:0] map_q;
    logic                   start_q, done_q, wexp_q, launched_q;

    logic [NUM_SECTORS-1:0] sel_1h;
    logic                   addr_ok;
    cmd_t                   cmd;
    logic                   win_last, win_restart, win_run;
    logic                   eng_done, eng_hold;

    sebc_sel_decode #(.NUM_SECTORS(NUM_SECTORS), .AW(AW)) u_dec (
        .addr(sec_addr), .onehot(sel_1h), .valid(addr_ok)
    );

    assign cmd = cmd_pick(cmd_add && addr_ok, cmd_other, cmd_suspend, cmd_resume);

    assign win_restart = cmd.add && (phase_q == PH_IDLE || phase_q == PH_GATHER);
    assign win_run     = (phase_q == PH_GATHER);

    sebc_window #(.CYCLES(WINDOW_CYCLES)) u_win (
        .clk(clk), .rst(rst), .restart(win_restart), .run(win_run), .last(win_last)
    );

    assign eng_hold = (phase_q == PH_HALT);

    sebc_engine #(.CYCLES(ERASE_CYCLES)) u_eng (
        .clk(clk), .rst(rst), .start(start_q), .hold(eng_hold), .done(eng_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            map_q      <= '0;
            start_q    <= 1'b0;
            done_q     <= 1'b0;
            wexp_q     <= 1'b0;
            launched_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (cmd.add) begin
                        map_q      <= sel_1h;
                        phase_q    <= PH_GATHER;
                        launched_q <= 1'b0;
                    end
                end
                PH_GATHER: begin
                    if (cmd.add) begin
                        map_q <= map_q | sel_1h;
                    end else if (cmd.abort) begin
                        map_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else if (cmd.halt) begin
                        phase_q <= PH_HALT;
                        wexp_q  <= 1'b1;
                    end else if (win_last) begin
                        phase_q    <= PH_ERASE;
                        start_q    <= 1'b1;
                        launched_q <= 1'b1;
                        wexp_q     <= 1'b1;
                    end
                end
                PH_ERASE: begin
                    if (eng_done) begin
                        phase_q <= PH_IDLE;
                        map_q   <= '0;
                        wexp_q  <= 1'b0;
                        done_q  <= 1'b1;
                    end else if (cmd.halt) begin
                        phase_q <= PH_HALT;
                    end
                end
                PH_HALT: begin
                    if (eng_done) begin
                        phase_q <= PH_IDLE;
                        map_q   <= '0;
                        wexp_q  <= 1'b0;
                        done_q  <= 1'b1;
                    end else if (cmd.go_on) begin
                        phase_q <= PH_ERASE;
                        if (!launched_q) begin
                            start_q    <= 1'b1;
                            launched_q <= 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign sel_map     = map_q;
    assign erase_start = start_q;
    assign busy        = (phase_q != PH_IDLE);
    assign win_expired = wexp_q;
    assign erase_done  = done_q;

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    p_start_closed_r4: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (wexp_q && phase_q == PH_ERASE));

    p_abort_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GATHER && cmd.abort) |=> (map_q == '0 && phase_q == PH_IDLE));

    p_erase_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ERASE && !eng_done) |=> $stable(map_q));

    p_halt_no_done_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HALT && $past(phase_q == PH_HALT)) |-> !eng_done);

    p_done_release_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (map_q == '0 && phase_q == PH_IDLE && !wexp_q));

    p_idle_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> (map_q == '0 && !wexp_q));
endmodule

// File: tb/sector_erase_batcher_tb.sv
module sector_erase_batcher_tb_top;
    localparam int NS = 16;
    localparam int W  = 20;
    localparam int E  = 30;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_add = 0, cmd_suspend = 0, cmd_resume = 0, cmd_other = 0;
    logic [AW-1:0] sec_addr = '0;
    logic [NS-1:0] sel_map;
    logic erase_start, busy, win_expired, erase_done;

    always #5 clk = ~clk;

    sector_erase_batcher #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W), .ERASE_CYCLES(E)) dut_i (
        .clk(clk), .rst(rst), .cmd_add(cmd_add), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_other(cmd_other), .sec_addr(sec_addr),
        .sel_map(sel_map), .erase_start(erase_start), .busy(busy),
        .win_expired(win_expired), .erase_done(erase_done)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model: 0 idle, 1 window open, 2 erasing, 3 suspended
    int            m_ph = 0;
    logic [NS-1:0] m_map = '0;
    int            m_win = 0;
    bit            m_launched = 0, m_start = 0, m_done = 0, m_wexp = 0;
    bit            e_run = 0, e_done = 0;
    int            e_left = 0;

    always @(posedge clk) begin
        int ph; logic [NS-1:0] mp; int wn; bit la, st, dn, wx;
        bit er, ed; int el;
        if (rst) begin
            m_ph = 0; m_map = '0; m_win = 0; m_launched = 0; m_start = 0;
            m_done = 0; m_wexp = 0; e_run = 0; e_done = 0; e_left = 0;
        end else begin
            er = e_run; ed = 0; el = e_left;
            if (m_start) begin er = 1; el = E; end
            else if (e_run && m_ph != 3) begin
                el = e_left - 1;
                if (el == 0) begin er = 0; ed = 1; end
            end
            ph = m_ph; mp = m_map; wn = m_win; la = m_launched; st = 0; dn = 0; wx = m_wexp;
            case (m_ph)
                0: if (cmd_add) begin mp = NS'(1) << sec_addr; wn = 0; ph = 1; la = 0; end
                1: begin
                    if (cmd_add) begin mp = m_map | (NS'(1) << sec_addr); wn = 0; end
                    else if (cmd_other) begin mp = '0; ph = 0; end
                    else if (cmd_suspend) begin ph = 3; wx = 1; end
                    else if (m_win == W - 1) begin ph = 2; st = 1; la = 1; wx = 1; end
                    else wn = m_win + 1;
                end
                2: begin
                    if (e_done) begin ph = 0; mp = '0; wx = 0; dn = 1; end
                    else if (!cmd_add && !cmd_other && cmd_suspend) ph = 3;
                end
                default: begin
                    if (e_done) begin ph = 0; mp = '0; wx = 0; dn = 1; end
                    else if (!cmd_add && !cmd_other && !cmd_suspend && cmd_resume) begin
                        ph = 2;
                        if (!m_launched) begin st = 1; la = 1; end
                    end
                end
            endcase
            m_ph = ph; m_map = mp; m_win = wn; m_launched = la; m_start = st;
            m_done = dn; m_wexp = wx; e_run = er; e_done = ed; e_left = el;
        end
    end

    int start_cnt = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk(sel_map == m_map, {cur_req, " model sel_map"}, 64'(sel_map), 64'(m_map));
            chk(erase_start == m_start, {cur_req, " model erase_start"}, 64'(erase_start), 64'(m_start));
            chk(busy == (m_ph != 0), {cur_req, " model busy"}, 64'(busy), 64'(m_ph != 0));
            chk(win_expired == m_wexp, {cur_req, " model win_expired"}, 64'(win_expired), 64'(m_wexp));
            chk(erase_done == m_done, {cur_req, " model erase_done"}, 64'(erase_done), 64'(m_done));
            if (erase_start) start_cnt++;
            if (erase_done) done_cnt++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int kind, input int a);
        @(negedge clk);
        sec_addr = AW'(a);
        cmd_add = (kind == 0); cmd_other = (kind == 1);
        cmd_suspend = (kind == 2); cmd_resume = (kind == 3);
        @(negedge clk);
        cmd_add = 0; cmd_other = 0; cmd_suspend = 0; cmd_resume = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!erase_start && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!erase_done && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R9 act=hung exp=finished");
        finish_run();
    end

    initial begin
        int n, sc, dc;
        int order[16] = '{9, 2, 15, 0, 11, 4, 7, 13, 1, 14, 6, 3, 10, 8, 5, 12};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        chk(sel_map == '0 && !busy && !win_expired && !erase_start && !erase_done, "R1 reset outputs",
            {sel_map, busy, win_expired, erase_start, erase_done}, 64'h0);

        // R2 first add, R3 accumulate with repeat
        cur_req = "R2";
        strobe(0, 3);
        chk(busy == 1'b1, "R2 busy after first add", 64'(busy), 64'h1);
        chk(sel_map == 16'h0008, "R2 single bit", 64'(sel_map), 64'h0008);
        cur_req = "R3";
        strobe(0, 7); strobe(0, 3); strobe(0, 0);
        chk(sel_map == 16'h0089, "R3 accumulated map", 64'(sel_map), 64'h0089);

        // R4 window length from last add
        cur_req = "R4";
        idle(W - 1);
        chk(erase_start == 1'b0 && win_expired == 1'b0, "R4 still open one cycle before",
            {erase_start, win_expired}, 64'h0);
        idle(1);
        chk(erase_start == 1'b1 && win_expired == 1'b1, "R4 launch at window end",
            {erase_start, win_expired}, 64'h3);
        // R9 latency and release
        cur_req = "R9";
        wait_done(n);
        chk(n == E + 2, "R9 done latency", 64'(n), 64'(E + 2));
        chk(sel_map == '0 && !busy && !win_expired, "R9 release at done",
            {sel_map, busy, win_expired}, 64'h0);
        idle(1);
        chk(erase_done == 1'b0, "R9 done one cycle", 64'(erase_done), 64'h0);

        // R5 abort by other command
        cur_req = "R5";
        sc = start_cnt;
        strobe(0, 1); idle(3); strobe(1, 0);
        chk(sel_map == '0 && !busy, "R5 abort clears", {sel_map, busy}, 64'h0);
        idle(W + 5);
        chk(start_cnt == sc, "R5 no erase after abort", 64'(start_cnt), 64'(sc));

        // R6 suspend in window, then resume
        cur_req = "R6";
        sc = start_cnt;
        strobe(0, 2); idle(3); strobe(2, 0);
        chk(win_expired && busy && !erase_start, "R6 suspend closes window",
            {win_expired, busy, erase_start}, 64'h6);
        idle(W + 5);
        chk(start_cnt == sc, "R6 no launch while suspended", 64'(start_cnt), 64'(sc));
        strobe(3, 0);
        chk(erase_start == 1'b1, "R6 resume launches", 64'(erase_start), 64'h1);
        wait_done(n);
        chk(erase_done == 1'b1 && sel_map == '0, "R6 completes", {erase_done, sel_map}, 64'h10000);

        // R7 commands ignored while erasing; R8 suspend freezes engine; R11 resume ignored when running
        cur_req = "R7";
        strobe(0, 4);
        wait_start(n);
        strobe(0, 9); strobe(1, 0);
        chk(sel_map == 16'h0010 && busy && win_expired, "R7 ignored while erasing",
            {sel_map, busy, win_expired}, {16'h0010, 2'b11});
        cur_req = "R11";
        strobe(3, 0);
        chk(sel_map == 16'h0010 && busy, "R11 resume while running ignored", {sel_map, busy}, {16'h0010, 1'b1});
        cur_req = "R8";
        dc = done_cnt;
        strobe(2, 0);
        idle(E + 10);
        chk(done_cnt == dc && busy, "R8 frozen while suspended", {32'(done_cnt), busy}, {32'(dc), 1'b1});
        strobe(3, 0);
        wait_done(n);
        chk(erase_done == 1'b1 && sel_map == '0, "R8 completes after resume", {erase_done, sel_map}, 64'h10000);

        // R11 suspend/resume in idle
        cur_req = "R11";
        idle(2);
        strobe(2, 0); strobe(3, 0);
        chk(!busy && sel_map == '0 && !win_expired && !erase_start, "R11 idle strobes ignored",
            {busy, sel_map, win_expired, erase_start}, 64'h0);

        // R3 all sectors in shuffled order
        cur_req = "R3";
        foreach (order[i]) strobe(0, order[i]);
        strobe(0, 9);
        chk(sel_map == 16'hFFFF, "R3 all sectors selected", 64'(sel_map), 64'hFFFF);
        wait_start(n);
        wait_done(n);
        chk(sel_map == '0 && !busy, "R3 all-sector erase releases", {sel_map, busy}, 64'h0);

        // R10 reset in window and during erase
        cur_req = "R10";
        strobe(0, 5); idle(3);
        do_reset();
        chk(sel_map == '0 && !busy && !win_expired, "R10 reset in window", {sel_map, busy, win_expired}, 64'h0);
        sc = start_cnt;
        idle(W + 5);
        chk(start_cnt == sc, "R10 no launch after reset", 64'(start_cnt), 64'(sc));
        strobe(0, 6);
        wait_start(n);
        idle(3);
        do_reset();
        chk(sel_map == '0 && !busy && !win_expired, "R10 reset while erasing", {sel_map, busy, win_expired}, 64'h0);
        dc = done_cnt;
        idle(E + 10);
        chk(done_cnt == dc, "R10 no done after reset", 64'(done_cnt), 64'(dc));

        idle(2);
        finish_run();
    end
endmodule